// File: doc/BRIEF.md
# Integer ALU with Operation Decode

This block is the integer arithmetic and logic unit of a 32-bit RV32I-class core, together with the small decoder that sits in front of it. The decoder takes the major opcode, the three-bit function field and bit 5 of the seven-bit function field. From these it picks one of ten operations. The same datapath serves several jobs: register-register arithmetic, register-immediate arithmetic, branch comparison by subtraction, and address formation by addition for loads, stores and jumps.

The caller supplies both operands already selected, whether from registers, an immediate or the program counter. The block returns the result and a flag that is high when the result is zero. Both outputs are registered, so they appear one clock after the inputs are presented.

Top module: `ialu_unit`

## Requirements
- R1: With opcode 0110011, the code {funct7_b5, funct3} selects the operation: 0000 add, 1000 subtract, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 0101 logical shift right, 1101 arithmetic shift right, 110 or, 111 and. funct7_b5 has no effect for funct3 values other than 000 and 101.
- R2: Signed less-than treats the operands as two's complement values. Unsigned less-than treats them as unsigned values. Both return 1 when true and 0 when false.
- R3: All shifts use only bits 4:0 of opnd_b as the shift amount, and ignore its upper bits.
- R4: Arithmetic shift right fills the vacated upper bits with bit 31 of opnd_a.
- R5: With opcode 0010011, the operations are the same as under R1, except that funct3 000 always adds, whatever the value of funct7_b5. funct7_b5 takes effect only when funct3 is 101.
- R6: With opcode 1100011 (branch), the result is opnd_a minus opnd_b, whatever funct3 and funct7_b5 hold.
- R7: With opcode 0000011 (load), 0100011 (store), 1101111 (jump and link), or any other opcode not named above, the result is opnd_a plus opnd_b.
- R8: zero is 1 exactly when the 32-bit result is 0.
- R9: result and zero update on the rising clock edge that samples the inputs, which gives a latency of one cycle.
- R10: While rst_n is low, result is 0 and zero is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 7 | Major opcode of the instruction |
| funct3 | input | 3 | Three-bit function field |
| funct7_b5 | input | 1 | Bit 5 of the seven-bit function field |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand or immediate |
| result | output | 32 | Registered result |
| zero | output | 1 | High when result is zero |

## Verification
The bench builds the block with the default XLEN of 32. At that width the sign bit, the all-ones and most-negative operands, and shift amounts of 0 and 31 all fall inside the shift range of five bits. This lets every boundary of the signed and unsigned compares and of the sign-filling shift be reached. Shift operands with junk in their upper bits test that only the low five bits count. Opcodes outside the named set test that they fall back to addition.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
        OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND
    } alu_op_e;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
    import ialu_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic       funct7_b5,
    output alu_op_e    op
);
    logic is_reg;
    logic is_imm;
    logic alt;

    always_comb begin
        is_reg = (opcode == OPC_REG);
        is_imm = (opcode == OPC_IMM);
        // alternate bit only matters for subtract (register form) and shift right
        alt    = funct7_b5 && ((funct3 == 3'b101) || (is_reg && funct3 == 3'b000));
        op     = OP_ADD;
        if (is_reg || is_imm) begin
            unique case (funct3)
                3'b000:  op = alt ? OP_SUB : OP_ADD;
                3'b001:  op = OP_SLL;
                3'b010:  op = OP_SLT;
                3'b011:  op = OP_SLTU;
                3'b100:  op = OP_XOR;
                3'b101:  op = alt ? OP_SRA : OP_SRL;
                3'b110:  op = OP_OR;
                default: op = OP_AND;
            endcase
        end else if (opcode == OPC_BRANCH) begin
            op = OP_SUB;
        end
    end
endmodule

// File: rtl/ialu_core.sv
module ialu_core
    import ialu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] shamt;
    logic           lt_s;
    logic           lt_u;

    always_comb begin
        shamt = b[SHW-1:0];
        lt_s  = $signed(a) < $signed(b);
        lt_u  = a < b;
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_SLL:  y = a << shamt;
            OP_SLT:  y = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: y = {{(XLEN-1){1'b0}}, lt_u};
            OP_XOR:  y = a ^ b;
            OP_SRL:  y = a >> shamt;
            OP_SRA:  y = XLEN'($signed(a) >>> shamt);
            OP_OR:   y = a | b;
            default: y = a & b;
        endcase
    end
endmodule

// File: rtl/ialu_unit.sv
module ialu_unit
    import ialu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [6:0]      opcode,
    input  logic [2:0]      funct3,
    input  logic            funct7_b5,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] result,
    output logic            zero
);
    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            zf;
    } out_t;

    alu_op_e         op;
    logic [XLEN-1:0] y;
    out_t            st_d;
    out_t            st_q;

    ialu_decode u_dec (
        .opcode    (opcode),
        .funct3    (funct3),
        .funct7_b5 (funct7_b5),
        .op        (op)
    );

    ialu_core #(.XLEN(XLEN)) u_core (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (y)
    );

    always_comb begin
        st_d.res = y;
        st_d.zf  = (y == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.res <= '0;
            st_q.zf  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.res;
    assign zero   = st_q.zf;
endmodule

// File: rtl/ialu_unit_chk.sv
module ialu_unit_chk
    import ialu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [6:0]      opcode,
    input logic [2:0]      funct3,
    input logic            funct7_b5,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic [XLEN-1:0] result,
    input logic            zero
);
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (zero == (result == '0))); // R8

    AST_BRANCH_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_BRANCH) |=> (result == $past(opnd_a - opnd_b))); // R6

    AST_ADDR_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_LOAD || opcode == OPC_STORE || opcode == OPC_JAL)
        |=> (result == $past(opnd_a + opnd_b))); // R7

    AST_IMM_NO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_IMM && funct3 == 3'b000 && funct7_b5)
        |=> (result == $past(opnd_a + opnd_b))); // R5

    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OPC_REG || opcode == OPC_IMM) && (funct3 == 3'b010 || funct3 == 3'b011))
        |=> (result[XLEN-1:1] == '0)); // R2
endmodule

bind ialu_unit ialu_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/ialu_unit_test.sv
module ialu_unit_test;
    localparam int XLEN = 32;

    typedef struct {
        logic [31:0] res;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  opcode = 7'b0110011;
    logic [2:0]  funct3 = '0;
    logic        funct7_b5 = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        zero;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    ialu_unit #(.XLEN(XLEN)) uut (.*);

    function automatic logic [31:0] model(input logic [6:0] opc, input logic [2:0] f3,
                                          input logic f7, input logic [31:0] a,
                                          input logic [31:0] b);
        int sh;
        logic [31:0] r;
        sh = int'(b[4:0]);
        if (opc == 7'b1100011) return a - b;
        if (opc != 7'b0110011 && opc != 7'b0010011) return a + b;
        case (f3)
            3'b000: return (opc == 7'b0110011 && f7) ? a - b : a + b;
            3'b001: begin
                r = a;
                for (int i = 0; i < sh; i++) r = {r[30:0], 1'b0};
                return r;
            end
            3'b010: return ((a[31] & ~b[31]) | ((a[31] == b[31]) & (a < b))) ? 32'd1 : 32'd0;
            3'b011: return (a < b) ? 32'd1 : 32'd0;
            3'b100: return a ^ b;
            3'b101: begin
                r = a;
                for (int i = 0; i < sh; i++) r = {f7 ? r[31] : 1'b0, r[31:1]};
                return r;
            end
            3'b110: return a | b;
            default: return a & b;
        endcase
    endfunction

    task automatic drive(input logic [6:0] opc, input logic [2:0] f3, input logic f7,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        opcode = opc; funct3 = f3; funct7_b5 = f7; opnd_a = a; opnd_b = b;
        e.res = model(opc, f3, f7, a, b);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: result of the inputs driven before an edge is sampled 1 ns after it (R9)
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (result !== e.res) begin
                failures++;
                $display("FAIL %s result=%h expected=%h", e.tag, result, e.res);
            end
            checks++;
            if (zero !== (e.res == 32'd0)) begin
                failures++;
                $display("FAIL R8 %s zero=%b expected=%b", e.tag, zero, e.res == 32'd0);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #400000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] corner [4];
        corner[0] = 32'h8000_0000; corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h0000_0000; corner[3] = 32'h7FFF_FFFF;

        // R10: reset state, with active inputs that must not show through
        opnd_a = 32'h1234_5678; opnd_b = 32'h1;
        repeat (3) @(negedge clk);
        checks++;
        if (result !== 32'd0 || zero !== 1'b1) begin
            failures++;
            $display("FAIL R10 result=%h zero=%b expected=00000000 1", result, zero);
        end
        rst_n = 1'b1;

        // R1 register-register operations
        drive(7'b0110011, 3'b000, 1'b0, 32'd7, 32'd5, "R1_add");
        drive(7'b0110011, 3'b000, 1'b1, 32'd7, 32'd5, "R1_sub");
        drive(7'b0110011, 3'b000, 1'b1, 32'd5, 32'd5, "R1_sub_zero");
        drive(7'b0110011, 3'b100, 1'b1, 32'hF0F0_F0F0, 32'h0FF0_0FF0, "R1_xor_f7_ignored");
        drive(7'b0110011, 3'b110, 1'b1, 32'hF000_0000, 32'h0000_000F, "R1_or_f7_ignored");
        drive(7'b0110011, 3'b111, 1'b0, 32'hFF00_FF00, 32'h0FF0_0FF0, "R1_and");
        // R2 compares at the sign boundary
        drive(7'b0110011, 3'b010, 1'b0, 32'h8000_0000, 32'h0000_0001, "R2_slt_neg");
        drive(7'b0110011, 3'b011, 1'b0, 32'h8000_0000, 32'h0000_0001, "R2_sltu_big");
        drive(7'b0110011, 3'b010, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2_slt_equal");
        drive(7'b0010011, 3'b011, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, "R2_sltiu");
        // R3 shift amount from low 5 bits only
        drive(7'b0110011, 3'b001, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, "R3_sll_31");
        drive(7'b0110011, 3'b001, 1'b0, 32'h0000_0001, 32'h0000_0020, "R3_sll_32_is_0");
        drive(7'b0110011, 3'b101, 1'b0, 32'h8000_0000, 32'h0000_001F, "R3_srl_31");
        // R4 arithmetic shift right
        drive(7'b0110011, 3'b101, 1'b1, 32'h8000_0000, 32'h0000_001F, "R4_sra_31");
        drive(7'b0110011, 3'b101, 1'b1, 32'h8000_0010, 32'h0000_0004, "R4_sra_4");
        drive(7'b0010011, 3'b101, 1'b1, 32'h4000_0000, 32'h0000_0401, "R4_srai_pos");
        drive(7'b0110011, 3'b101, 1'b1, 32'hF000_0000, 32'h0000_0000, "R4_sra_0");
        // R5 immediate form never subtracts
        drive(7'b0010011, 3'b000, 1'b1, 32'd10, 32'd3, "R5_addi_f7");
        drive(7'b0010011, 3'b001, 1'b1, 32'h0000_0003, 32'h0000_0002, "R5_slli_f7_ignored");
        // R6 branch subtracts regardless of funct3
        drive(7'b1100011, 3'b001, 1'b0, 32'd9, 32'd9, "R6_branch_eq");
        drive(7'b1100011, 3'b110, 1'b1, 32'd3, 32'd9, "R6_branch_lt");
        // R7 address forms and unknown opcodes add
        drive(7'b0000011, 3'b010, 1'b1, 32'h1000_0000, 32'hFFFF_FFFC, "R7_load");
        drive(7'b0100011, 3'b010, 1'b0, 32'h0000_0100, 32'h0000_0010, "R7_store");
        drive(7'b1101111, 3'b101, 1'b1, 32'h0000_0040, 32'hFFFF_FFC0, "R7_jal_zero");
        drive(7'b0110111, 3'b111, 1'b1, 32'd1, 32'd2, "R7_other");

        // corner operand pairs across every register and immediate code
        foreach (corner[i]) foreach (corner[j]) begin
            for (int c = 0; c < 16; c++) begin
                drive(7'b0110011, 3'(c), c[3], corner[i], corner[j], "R1_corner");
                drive(7'b0010011, 3'(c), c[3], corner[i], corner[j], "R5_corner");
            end
        end

        // random pairs, mixed opcodes
        for (int n = 0; n < 600; n++) begin
            logic [6:0] opc;
            case ($urandom_range(0, 5))
                0, 1: opc = 7'b0110011;
                2, 3: opc = 7'b0010011;
                4:    opc = 7'b1100011;
                default: opc = 7'b0000011;
            endcase
            drive(opc, 3'($urandom), 1'($urandom), $urandom, $urandom, "R1_R5_R6_R7_random");
        end

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; failures++;
            $display("FAIL R9 pending=%0d expected=0", sb.size());
        end
        finish_run();
    end
endmodule